// File: doc/BRIEF.md
# Clock-Sweep Victim Frame Selector

This block tracks recent use and modification of a fixed set of physical frames and picks a frame to evict when asked. Each frame has a use flag and a modified flag. A use pulse on a frame sets its use flag. A store pulse sets its modified flag. When an eviction candidate is needed, the block walks a circular pointer over the frames, one frame per clock cycle. A frame whose use flag is set loses that flag and the walk moves on, so the frame gets a second chance. The walk stops at the first frame whose use flag is already clear.

A request may ask for the clean-first policy. In that case the walk stops only at a frame that is both unused and unmodified. If a full turn of the pointer finds no such frame, the walk falls back to the ordinary rule and carries on from the same place. The chosen frame's index and its modified flag come out with a one-cycle `done` pulse. The pointer then rests on the frame after the victim, so the next walk starts there.

Requests use a valid/ready handshake. `req_ready` is high only while no walk is running. A request counts as accepted on a rising edge where both `req_valid` and `req_ready` are high. `clean_mode` is sampled on that same edge. While a walk runs, `req_ready` is low and `req_valid` is ignored, so the requester must hold its request until it sees ready. The result has no back-pressure: it is a plain pulse, and the requester must capture it in the cycle it appears. Use and store pulses are plain inputs and are taken on every edge.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every use flag, every modified flag and the pointer are zero, `busy` and `done` are low and `req_ready` is high. The first ordinary request therefore returns frame 0 as unmodified.
- R2: A use pulse sets that frame's use flag. The walk clears the use flag of every frame whose flag is set, passes it over, and returns the first frame whose flag is clear.
- R3: A store pulse sets that frame's modified flag. `victim_dirty` reports the victim's modified flag, where 1 means modified.
- R4: The walk examines exactly one frame per cycle. `done` rises k clock edges after the accepting edge, where k is the number of frames examined. `busy` is high from the accepting edge until `done` rises.
- R5: `done` is high for exactly one cycle, and `victim_idx` carries the chosen frame in that cycle.
- R6: After a victim is chosen, the pointer rests one position past it, and the next walk examines that frame first.
- R7: The pointer wraps from frame N-1 to frame 0.
- R8: With `clean_mode`=1 at acceptance, the walk passes over frames that are unused but modified and returns the first frame that is both unused and unmodified.
- R9: In clean-first mode, if a full turn of N frames finds no unused unmodified frame, the walk continues under the ordinary rule. The use flags cleared during the first turn let it finish within the second turn.
- R10: If a use pulse names the frame that the walk is clearing in the same cycle, the use flag stays set.
- R11: While a walk runs, `req_ready` is low and a held `req_valid` neither restarts nor changes the walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Victim request valid |
| req_ready | output | 1 | Block can accept a request (no walk running) |
| clean_mode | input | 1 | Use the clean-first policy for the request being accepted |
| ref_valid | input | 1 | Use pulse |
| ref_idx | input | IDXW | Frame named by the use pulse |
| wr_valid | input | 1 | Store pulse |
| wr_idx | input | IDXW | Frame named by the store pulse |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| victim_idx | output | IDXW | Chosen frame, valid while done is high |
| victim_dirty | output | 1 | Modified flag of the chosen frame, valid while done is high |

## Verification
The walk's clearing of a use flag and a fresh use pulse on the same frame can land on the same clock edge. The bench provokes this by starting a walk whose pointer sits on a used frame and driving a use pulse for that frame during the first examine cycle. It then judges the outcome on a later walk: that walk must pass over the frame again and pick the next unused frame. If the clear had won, that walk would stop one frame earlier and one cycle sooner.

// File: rtl/clock_nru_pkg.sv
package clock_nru_pkg;
  typedef enum logic { ST_IDLE, ST_SCAN } sweep_state_t;
  typedef enum logic { PASS_PLAIN, PASS_CLEAN } sweep_pass_t;
endpackage

// File: rtl/nru_frame_flags.sv
module nru_frame_flags #(
  parameter int N = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_ref,
  input  logic [$clog2(N)-1:0]       ref_idx,
  input  logic                       set_dirty,
  input  logic [$clog2(N)-1:0]       wr_idx,
  input  logic                       clr_ref,
  input  logic [$clog2(N)-1:0]       clr_idx,
  output logic [N-1:0]               ref_bits,
  output logic [N-1:0]               dirty_bits
);
  localparam int W = $clog2(N);

  for (genvar f = 0; f < N; f++) begin : g_frame
    logic hit_ref, hit_clr, hit_wr;
    assign hit_ref = set_ref   && (ref_idx == W'(f));
    assign hit_clr = clr_ref   && (clr_idx == W'(f));
    assign hit_wr  = set_dirty && (wr_idx  == W'(f));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_bits[f]   <= 1'b0;
        dirty_bits[f] <= 1'b0;
      end else begin
        // a fresh use outranks the sweep's clear
        if (hit_ref)      ref_bits[f] <= 1'b1;
        else if (hit_clr) ref_bits[f] <= 1'b0;
        if (hit_wr)       dirty_bits[f] <= 1'b1;
      end
    end
  end

  // R2
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ref |=> ref_bits[$past(ref_idx)]);
  // R3
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_dirty |=> dirty_bits[$past(wr_idx)]);
  // R10
  ref_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ref && clr_ref && ref_idx == clr_idx) |=> ref_bits[$past(clr_idx)]);
endmodule

// File: rtl/nru_sweep_ctrl.sv
module nru_sweep_ctrl
  import clock_nru_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   clean_mode,
  input  logic [N-1:0]           ref_bits,
  input  logic [N-1:0]           dirty_bits,
  output logic                   clr_ref,
  output logic [$clog2(N)-1:0]   clr_idx,
  output logic                   busy,
  output logic                   done,
  output logic [$clog2(N)-1:0]   victim_idx,
  output logic                   victim_dirty
);
  localparam int W = $clog2(N);
  localparam logic [W-1:0] LAST = W'(N - 1);

  sweep_state_t st_q;
  sweep_pass_t  pass_q;
  logic [W-1:0] ptr_q, cnt_q, ptr_nxt;
  logic         scanning, cur_ref, cur_dirty, hit;

  always_comb begin
    scanning  = (st_q == ST_SCAN);
    cur_ref   = ref_bits[ptr_q];
    cur_dirty = dirty_bits[ptr_q];
    hit       = scanning && !cur_ref && (pass_q == PASS_PLAIN || !cur_dirty);
    ptr_nxt   = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign clr_ref   = scanning && cur_ref;
  assign clr_idx   = ptr_q;
  assign busy      = scanning;
  assign req_ready = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      pass_q       <= PASS_PLAIN;
      ptr_q        <= '0;
      cnt_q        <= '0;
      done         <= 1'b0;
      victim_idx   <= '0;
      victim_dirty <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          st_q   <= ST_SCAN;
          pass_q <= clean_mode ? PASS_CLEAN : PASS_PLAIN;
          cnt_q  <= '0;
        end
        default: begin
          ptr_q <= ptr_nxt;
          if (hit) begin
            done         <= 1'b1;
            victim_idx   <= ptr_q;
            victim_dirty <= cur_dirty;
            st_q         <= ST_IDLE;
          end else if (pass_q == PASS_CLEAN && cnt_q == LAST) begin
            pass_q <= PASS_PLAIN;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  // R2
  victim_unref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ref_bits) & (N'(1) << victim_idx)) == '0);
  // R8
  clean_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(pass_q) == PASS_CLEAN) |-> !victim_dirty);
  // R6
  ptr_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ptr_q == ((victim_idx == LAST) ? '0 : victim_idx + 1'b1));
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            clean_mode,
  input  logic            ref_valid,
  input  logic [IDXW-1:0] ref_idx,
  input  logic            wr_valid,
  input  logic [IDXW-1:0] wr_idx,
  output logic            busy,
  output logic            done,
  output logic [IDXW-1:0] victim_idx,
  output logic            victim_dirty
);
  logic [N-1:0]    ref_bits, dirty_bits;
  logic            clr_ref;
  logic [IDXW-1:0] clr_idx;

  nru_frame_flags #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_ref(ref_valid), .ref_idx(ref_idx),
    .set_dirty(wr_valid), .wr_idx(wr_idx),
    .clr_ref(clr_ref), .clr_idx(clr_idx),
    .ref_bits(ref_bits), .dirty_bits(dirty_bits)
  );

  nru_sweep_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .clean_mode(clean_mode),
    .ref_bits(ref_bits), .dirty_bits(dirty_bits),
    .clr_ref(clr_ref), .clr_idx(clr_idx),
    .busy(busy), .done(done),
    .victim_idx(victim_idx), .victim_dirty(victim_dirty)
  );

  // R11
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

// File: tb/clock_victim_sel_bench.sv
module clock_victim_sel_bench;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, clean_mode = 1'b0;
  logic ref_valid = 1'b0, wr_valid = 1'b0;
  logic [W-1:0] ref_idx = '0, wr_idx = '0;
  logic req_ready, busy, done, victim_dirty;
  logic [W-1:0] victim_idx;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  clock_victim_sel #(.N(N)) u_clock_victim_sel (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .clean_mode(clean_mode),
    .ref_valid(ref_valid), .ref_idx(ref_idx),
    .wr_valid(wr_valid), .wr_idx(wr_idx),
    .busy(busy), .done(done),
    .victim_idx(victim_idx), .victim_dirty(victim_dirty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_ref(input int f);
    @(negedge clk); ref_valid = 1'b1; ref_idx = W'(f);
    @(negedge clk); ref_valid = 1'b0;
  endtask

  task automatic pulse_wr(input int f);
    @(negedge clk); wr_valid = 1'b1; wr_idx = W'(f);
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic start_req(input logic cm);
    @(negedge clk); req_valid = 1'b1; clean_mode = cm;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    chk(busy === 1'b1, "R4 busy after accept", int'(busy), 1);
  endtask

  task automatic wait_done(input int c0, input int e_idx, input int e_dirty,
                           input int e_cyc, input string tag);
    int cyc = c0;
    while (!done && cyc < 40) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    chk(cyc == e_cyc, {tag, " cycles"}, cyc, e_cyc);
    chk(victim_idx == W'(e_idx), {tag, " victim"}, int'(victim_idx), e_idx);
    chk(victim_dirty == e_dirty[0], {tag, " dirty"}, int'(victim_dirty), e_dirty);
    @(negedge clk);
    chk(done === 1'b0, "R5 single pulse", int'(done), 0);
    chk(busy === 1'b0, "R4 idle after done", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0, "R1 outputs low", int'({busy, done}), 0);
    chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
    start_req(1'b0);
    wait_done(0, 0, 0, 1, "R1 first plain");
  endtask

  task automatic t_second_chance();   // R2 R6: ptr=1
    pulse_ref(1); pulse_ref(2);
    start_req(1'b0);
    wait_done(0, 3, 0, 3, "R2 skip used");
  endtask

  task automatic t_dirty();           // R3: ptr=4
    pulse_wr(4);
    start_req(1'b0);
    wait_done(0, 4, 1, 1, "R3 dirty report");
  endtask

  task automatic t_wrap();            // R7: ptr=5
    pulse_ref(5); pulse_ref(6); pulse_ref(7);
    start_req(1'b0);
    wait_done(0, 0, 0, 4, "R7 wrap");
    start_req(1'b0);                  // R2 frame 1 flag was cleared earlier
    wait_done(0, 1, 0, 1, "R2 cleared flag");
  endtask

  task automatic t_clean();           // R8: ptr=2
    pulse_wr(2); pulse_wr(3);
    start_req(1'b1);
    wait_done(0, 5, 0, 4, "R8 clean first");
  endtask

  task automatic t_fallback();        // R9: ptr=6
    pulse_wr(0); pulse_wr(1); pulse_wr(5); pulse_wr(6); pulse_wr(7);
    pulse_ref(6);
    start_req(1'b1);
    wait_done(0, 6, 1, 9, "R9 fallback");
  endtask

  task automatic t_collision();       // R10: ptr=7
    pulse_ref(7); pulse_ref(0);
    start_req(1'b0);
    ref_valid = 1'b1; ref_idx = W'(7);  // same cycle the walk clears frame 7
    @(posedge clk);
    @(negedge clk); ref_valid = 1'b0;
    wait_done(1, 1, 1, 3, "R10 walk");
    for (int f = 2; f <= 6; f++) pulse_ref(f);
    start_req(1'b0);
    wait_done(0, 0, 1, 7, "R10 use kept");
  endtask

  task automatic t_hold_req();        // R11: ptr=1
    int cyc = 0;
    pulse_ref(1); pulse_ref(2);
    @(negedge clk); req_valid = 1'b1; clean_mode = 1'b0;
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (done || cyc >= 40) break;
      chk(req_ready === 1'b0, "R11 not ready while busy", int'(req_ready), 0);
      @(posedge clk); cyc++;
    end
    req_valid = 1'b0;
    chk(cyc == 3, "R11 cycles", cyc, 3);
    chk(victim_idx == W'(3), "R11 victim", int'(victim_idx), 3);
    @(negedge clk);
    chk(busy === 1'b0, "R11 no restart", int'(busy), 0);
    start_req(1'b0);
    wait_done(0, 4, 1, 1, "R6 rest past victim");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_second_chance();
    t_dirty();
    t_wrap();
    t_clean();
    t_fallback();
    t_collision();
    t_hold_req();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule